// File: doc/BRIEF.md
# Shape Slot Assignment Unit

This block distributes one 32-bit shape template over a bank of four shape registers and records, for each of five operand positions, which of those registers the operand is bound to. A command is issued with a single `start` pulse that carries the template, a 5-bit operand mask and a mode flag. The template is built elsewhere and arrives ready-made.

With the mode flag low (bulk mode) the unit first wipes every shape register and every mapping field. It then stores the mask as the operand enable field and visits the operand positions in ascending order, one position per clock. Each selected position takes the next shape register in rotation, and the rotation wraps after the last register. With the mode flag high (refined mode) the mask is read as a packed pair, an operand position and a slot number. Exactly one shape register and one mapping field are written, and that operand's enable bit is set. The mode flag is kept as a persistence bit for the sequencer that uses the mapping.

Top module: `shape_slot_assign`

## Requirements
- R1: After reset every shape register, every mapping field, the enable field and the persistence bit read zero, and `busy`, `done` and `err` are low.
- R2: A bulk command (`modeIn`=0) accepted at a clock edge leaves, right after that edge, all shape registers and mapping fields at zero, `enOut` equal to the command's mask, and `persistOut` at 0.
- R3: In bulk mode operand position p (0 to 4) is selected by mask bit p. Positions are visited in ascending order and the slot counter starts at 0. Each selected position copies the template into shape register `shapeOut[32*s+31:32*s]` of the current slot s and stores s in `opMapOut[2p+1:2p]`. Unselected positions keep mapping 0.
- R4: The slot counter advances only after a selected position and wraps from 3 back to 0. With mask 5'b11111, position 4 maps to slot 0.
- R5: A bulk command takes one clock per position. `done` is high for exactly one cycle, five clock edges after the accepting edge. `busy` is high from the accepting edge until `done` rises.
- R6: In refined mode (`modeIn`=1) the position is mask[4:2] and the slot is mask[1:0]. One edge after acceptance, the template is in that slot, the position's mapping field holds the slot, its enable bit is set and `persistOut` is 1. All other shapes, fields and enable bits are unchanged. `done` pulses for one cycle.
- R7: A refined command whose position field exceeds 4 changes no output state and raises `err` together with `done` for one cycle.
- R8: `start` is ignored while `busy` is high.
- R9: While idle with `start` low, the shape registers, mapping and enable fields hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe, accepted only when idle |
| modeIn | input | 1 | 0 = bulk assignment, 1 = refined single update |
| maskIn | input | 5 | Operand mask (bulk) or packed position/slot (refined) |
| templIn | input | 32 | Shape template to distribute |
| shapeOut | output | 128 | Four shape registers, slot s at bits 32s+31..32s |
| opMapOut | output | 10 | Slot number per operand, position p at bits 2p+1..2p |
| enOut | output | 5 | Operand enable field, bit p for position p |
| persistOut | output | 1 | Stored mode flag |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse for an invalid refined position |

## Verification
A new command can collide with the last step of a bulk walk. A refined `start` is held high during the cycle in which position 4 is written, so that the edge accepting nothing and the edge finishing the walk are the same. The run is judged correct if the final mapping equals the bulk result alone and no second `done` follows. A second collision is the wrap of the slot rotation onto a slot already written in the same walk. A full mask makes position 4 overwrite slot 0, and the bench checks that the mapping field shows 0 while slot 0 still holds the template.

// File: rtl/shape_slot_pkg.sv
package shape_slot_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WALK  = 2'd1,
    ST_APPLY = 2'd2
  } ctrlState_e;

  typedef struct packed {
    logic latch;     // capture template for a new command
    logic clearAll;  // bulk wipe plus enable field load
    logic writeEn;   // write template into slot and mapping field
    logic setEnBit;  // refined: set enable bit and persistence
  } strobe_t;

endpackage

// File: rtl/shape_slot_ctrl.sv
module shape_slot_ctrl
  import shape_slot_pkg::*;
#(
  parameter int NUM_OPS   = 5,
  parameter int NUM_SLOTS = 4,
  localparam int POS_W    = $clog2(NUM_OPS),
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int REF_W    = NUM_OPS - SLOT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              modeIn,
  input  logic [NUM_OPS-1:0] maskIn,
  output strobe_t           strb,
  output logic [POS_W-1:0]  posSel,
  output logic [SLOT_W-1:0] slotSel,
  output logic              busy,
  output logic              done,
  output logic              err
);

  localparam logic [POS_W-1:0]  LAST_POS  = POS_W'(NUM_OPS - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  ctrlState_e            stateQ, stateD;
  logic [NUM_OPS-1:0]    maskQ;
  logic [POS_W-1:0]      posQ, posD;
  logic [SLOT_W-1:0]     slotQ, slotD;
  logic                  doneD, errD;
  logic [REF_W-1:0]      refPos;
  logic [SLOT_W-1:0]     refSlot;
  logic                  refBad;
  logic                  accept;

  assign refPos  = maskQ[NUM_OPS-1:SLOT_W];
  assign refSlot = maskQ[SLOT_W-1:0];
  assign refBad  = (refPos > REF_W'(NUM_OPS - 1));
  assign accept  = start && (stateQ == ST_IDLE);
  assign busy    = (stateQ != ST_IDLE);

  always_comb begin
    stateD  = stateQ;
    posD    = posQ;
    slotD   = slotQ;
    doneD   = 1'b0;
    errD    = 1'b0;
    strb    = '0;
    posSel  = posQ;
    slotSel = slotQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (accept) begin
          strb.latch    = 1'b1;
          strb.clearAll = !modeIn;
          posD          = '0;
          slotD         = '0;
          stateD        = modeIn ? ST_APPLY : ST_WALK;
        end
      end
      ST_WALK: begin
        if (maskQ[posQ]) begin
          strb.writeEn = 1'b1;
          slotD        = (slotQ == LAST_SLOT) ? '0 : slotQ + 1'b1;
        end
        if (posQ == LAST_POS) begin
          doneD  = 1'b1;
          stateD = ST_IDLE;
        end else begin
          posD = posQ + 1'b1;
        end
      end
      ST_APPLY: begin
        posSel  = POS_W'(refPos);
        slotSel = refSlot;
        if (refBad) begin
          errD = 1'b1;
        end else begin
          strb.writeEn  = 1'b1;
          strb.setEnBit = 1'b1;
        end
        doneD  = 1'b1;
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      maskQ  <= '0;
      posQ   <= '0;
      slotQ  <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      stateQ <= stateD;
      posQ   <= posD;
      slotQ  <= slotD;
      done   <= doneD;
      err    <= errD;
      if (accept) maskQ <= maskIn;
    end
  end

endmodule

// File: rtl/shape_slot_dpath.sv
module shape_slot_dpath
  import shape_slot_pkg::*;
#(
  parameter int NUM_OPS   = 5,
  parameter int NUM_SLOTS = 4,
  parameter int SHAPE_W   = 32,
  localparam int POS_W    = $clog2(NUM_OPS),
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       strb,
  input  logic [POS_W-1:0]              posSel,
  input  logic [SLOT_W-1:0]             slotSel,
  input  logic [NUM_OPS-1:0]            maskIn,
  input  logic [SHAPE_W-1:0]            templIn,
  output logic [NUM_SLOTS*SHAPE_W-1:0]  shapeOut,
  output logic [NUM_OPS*SLOT_W-1:0]     opMapOut,
  output logic [NUM_OPS-1:0]            enOut,
  output logic                          persistOut
);

  logic [SHAPE_W-1:0] templQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      templQ     <= '0;
      persistOut <= 1'b0;
    end else begin
      if (strb.latch) templQ <= templIn;
      if (strb.clearAll) persistOut <= 1'b0;
      else if (strb.setEnBit) persistOut <= 1'b1;
    end
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [SHAPE_W-1:0] shapeQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shapeQ <= '0;
      end else if (strb.clearAll) begin
        shapeQ <= '0;
      end else if (strb.writeEn && (slotSel == SLOT_W'(s))) begin
        shapeQ <= templQ;
      end
    end
    assign shapeOut[s*SHAPE_W +: SHAPE_W] = shapeQ;
  end

  for (genvar p = 0; p < NUM_OPS; p++) begin : g_op
    logic [SLOT_W-1:0] mapQ;
    logic              enQ;
    logic              hit;
    assign hit = (posSel == POS_W'(p));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        mapQ <= '0;
        enQ  <= 1'b0;
      end else if (strb.clearAll) begin
        mapQ <= '0;
        enQ  <= maskIn[p];
      end else begin
        if (strb.writeEn && hit) mapQ <= slotSel;
        if (strb.setEnBit && hit) enQ <= 1'b1;
      end
    end
    assign opMapOut[p*SLOT_W +: SLOT_W] = mapQ;
    assign enOut[p] = enQ;
  end

endmodule

// File: rtl/shape_slot_assign.sv
module shape_slot_assign
  import shape_slot_pkg::*;
#(
  parameter int NUM_OPS   = 5,
  parameter int NUM_SLOTS = 4,
  parameter int SHAPE_W   = 32,
  localparam int POS_W    = $clog2(NUM_OPS),
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         start,
  input  logic                         modeIn,
  input  logic [NUM_OPS-1:0]           maskIn,
  input  logic [SHAPE_W-1:0]           templIn,
  output logic [NUM_SLOTS*SHAPE_W-1:0] shapeOut,
  output logic [NUM_OPS*SLOT_W-1:0]    opMapOut,
  output logic [NUM_OPS-1:0]           enOut,
  output logic                         persistOut,
  output logic                         busy,
  output logic                         done,
  output logic                         err
);

  strobe_t           strb;
  logic [POS_W-1:0]  posSel;
  logic [SLOT_W-1:0] slotSel;

  shape_slot_ctrl #(.NUM_OPS(NUM_OPS), .NUM_SLOTS(NUM_SLOTS)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .modeIn(modeIn), .maskIn(maskIn),
    .strb(strb), .posSel(posSel), .slotSel(slotSel),
    .busy(busy), .done(done), .err(err)
  );

  shape_slot_dpath #(.NUM_OPS(NUM_OPS), .NUM_SLOTS(NUM_SLOTS), .SHAPE_W(SHAPE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .posSel(posSel), .slotSel(slotSel),
    .maskIn(maskIn), .templIn(templIn), .shapeOut(shapeOut),
    .opMapOut(opMapOut), .enOut(enOut), .persistOut(persistOut)
  );

endmodule

// File: rtl/shape_slot_checker.sv
module shape_slot_checker #(
  parameter int NUM_OPS   = 5,
  parameter int NUM_SLOTS = 4,
  parameter int SHAPE_W   = 32,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         start,
  input logic                         modeIn,
  input logic [NUM_OPS-1:0]           maskIn,
  input logic [NUM_SLOTS*SHAPE_W-1:0] shapeOut,
  input logic [NUM_OPS*SLOT_W-1:0]    opMapOut,
  input logic [NUM_OPS-1:0]           enOut,
  input logic                         persistOut,
  input logic                         busy,
  input logic                         done,
  input logic                         err
);

  // R2: bulk acceptance wipes state and loads the enable field
  p_bulk_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !modeIn) |=> (shapeOut == '0) && (opMapOut == '0)
                                    && (enOut == $past(maskIn)) && !persistOut);

  // R5: completion is a single-cycle pulse outside busy
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R6: a refined command does not touch state on its accepting edge
  p_refine_latch_r6: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && modeIn) |=> $stable(shapeOut) && $stable(opMapOut) && $stable(enOut));

  // R7: a rejection comes with done and leaves the mapping untouched
  p_err_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    err |-> done);
  p_err_nochange_r7: assert property (@(posedge clk) disable iff (!rstN)
    err |-> $stable(shapeOut) && $stable(opMapOut) && $stable(enOut) && $stable(persistOut));

  // R9: idle without a command holds state
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(shapeOut) && $stable(opMapOut) && $stable(enOut));

endmodule

bind shape_slot_assign shape_slot_checker #(
  .NUM_OPS(NUM_OPS), .NUM_SLOTS(NUM_SLOTS), .SHAPE_W(SHAPE_W)
) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .modeIn(modeIn), .maskIn(maskIn),
  .shapeOut(shapeOut), .opMapOut(opMapOut), .enOut(enOut), .persistOut(persistOut),
  .busy(busy), .done(done), .err(err)
);

// File: tb/test_shape_slot_assign.sv
`timescale 1ns/1ps
module test_shape_slot_assign;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic         modeIn = 1'b0;
  logic [4:0]   maskIn = '0;
  logic [31:0]  templIn = '0;
  logic [127:0] shapeOut;
  logic [9:0]   opMapOut;
  logic [4:0]   enOut;
  logic         persistOut, busy, done, err;

  int nChecks = 0;
  int nFails  = 0;

  // expected state, built from the requirements
  logic [31:0] expShape [4];
  logic [1:0]  expMap   [5];
  logic [4:0]  expEn;
  logic        expPersist;

  always #2 clk = ~clk;

  shape_slot_assign i_shape_slot_assign (
    .clk(clk), .rstN(rstN), .start(start), .modeIn(modeIn), .maskIn(maskIn),
    .templIn(templIn), .shapeOut(shapeOut), .opMapOut(opMapOut), .enOut(enOut),
    .persistOut(persistOut), .busy(busy), .done(done), .err(err)
  );

  task automatic check(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic checkState(input string req);
    for (int s = 0; s < 4; s++)
      check(req, $sformatf("shape%0d", s), 128'(shapeOut[s*32 +: 32]), 128'(expShape[s]));
    for (int p = 0; p < 5; p++)
      check(req, $sformatf("map%0d", p), 128'(opMapOut[p*2 +: 2]), 128'(expMap[p]));
    check(req, "enable", 128'(enOut), 128'(expEn));
    check(req, "persist", 128'(persistOut), 128'(expPersist));
  endtask

  function automatic void modelBulk(input logic [4:0] m, input logic [31:0] t);
    int slot = 0;
    for (int s = 0; s < 4; s++) expShape[s] = '0;
    for (int p = 0; p < 5; p++) expMap[p] = '0;
    expEn = m;
    expPersist = 1'b0;
    for (int p = 0; p < 5; p++) begin
      if (m[p]) begin
        expShape[slot] = t;
        expMap[p] = 2'(slot);
        slot = (slot == 3) ? 0 : slot + 1;
      end
    end
  endfunction

  function automatic void modelRefine(input logic [4:0] m, input logic [31:0] t);
    int p = int'(m[4:2]);
    int s = int'(m[1:0]);
    if (p <= 4) begin
      expShape[s] = t;
      expMap[p] = 2'(s);
      expEn[p] = 1'b1;
      expPersist = 1'b1;
    end
  endfunction

  // issue a command; returns edges after acceptance until done, and err seen
  task automatic issue(input logic md, input logic [4:0] m, input logic [31:0] t,
                       output int cycles, output logic sawErr);
    @(negedge clk);
    start = 1'b1; modeIn = md; maskIn = m; templIn = t;
    @(negedge clk);
    start = 1'b0;
    cycles = 0; sawErr = 1'b0;
    while (!done && cycles < 20) begin
      @(negedge clk);
      cycles++;
    end
    sawErr = err;
  endtask

  task automatic testReset();
    for (int s = 0; s < 4; s++) expShape[s] = '0;
    for (int p = 0; p < 5; p++) expMap[p] = '0;
    expEn = '0; expPersist = 1'b0;
    checkState("R1");
    check("R1", "busy", 128'(busy), 0);
    check("R1", "done", 128'(done), 0);
    check("R1", "err", 128'(err), 0);
  endtask

  task automatic testBulkSparse();
    int cyc; logic e;
    // R2: clear state right after the accepting edge
    @(negedge clk);
    start = 1'b1; modeIn = 1'b0; maskIn = 5'b10110; templIn = 32'hA5A5_0001;
    @(negedge clk);
    start = 1'b0;
    check("R2", "shapes cleared", 128'(shapeOut), 0);
    check("R2", "enable loaded", 128'(enOut), 128'(5'b10110));
    check("R5", "busy during walk", 128'(busy), 1);
    cyc = 0;
    while (!done && cyc < 20) begin @(negedge clk); cyc++; end
    e = err;
    check("R5", "walk length", 128'(cyc), 5);
    check("R7", "no err on bulk", 128'(e), 0);
    modelBulk(5'b10110, 32'hA5A5_0001);
    checkState("R3");
    @(negedge clk);
    check("R5", "done single cycle", 128'(done), 0);
  endtask

  task automatic testBulkWrap();
    int cyc; logic e;
    issue(1'b0, 5'b11111, 32'h1234_5678, cyc, e);
    modelBulk(5'b11111, 32'h1234_5678);
    check("R4", "walk length", 128'(cyc), 5);
    check("R4", "pos4 wraps to slot0", 128'(opMapOut[9:8]), 0);
    checkState("R4");
  endtask

  task automatic testRefine();
    int cyc; logic e;
    issue(1'b1, {3'd2, 2'd3}, 32'hCAFE_0003, cyc, e);
    modelRefine({3'd2, 2'd3}, 32'hCAFE_0003);
    check("R6", "refine length", 128'(cyc), 1);
    check("R6", "no err", 128'(e), 0);
    checkState("R6");
    issue(1'b1, {3'd4, 2'd1}, 32'hBEEF_0041, cyc, e);
    modelRefine({3'd4, 2'd1}, 32'hBEEF_0041);
    checkState("R6");
  endtask

  task automatic testRefineBad();
    int cyc; logic e;
    issue(1'b1, {3'd6, 2'd2}, 32'hDEAD_0006, cyc, e);
    check("R7", "err raised", 128'(e), 1);
    check("R7", "done with err", 128'(cyc), 1);
    checkState("R7");
    @(negedge clk);
    check("R7", "err single cycle", 128'(err), 0);
  endtask

  task automatic testBusyIgnore();
    int cyc;
    @(negedge clk);
    start = 1'b1; modeIn = 1'b0; maskIn = 5'b01001; templIn = 32'h0F0F_0F0F;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (cyc < 4) begin @(negedge clk); cyc++; end
    // start collides with the edge that processes position 4
    start = 1'b1; modeIn = 1'b1; maskIn = {3'd0, 2'd2}; templIn = 32'h7777_7777;
    @(negedge clk);
    start = 1'b0;
    check("R8", "done at walk end", 128'(done), 1);
    modelBulk(5'b01001, 32'h0F0F_0F0F);
    checkState("R8");
    @(negedge clk);
    @(negedge clk);
    check("R8", "no extra done", 128'(done), 0);
    check("R8", "not busy", 128'(busy), 0);
  endtask

  task automatic testIdleHold();
    for (int k = 0; k < 6; k++) begin
      templIn = 32'h5555_0000 + 32'(k);
      maskIn = 5'(k);
      @(negedge clk);
    end
    checkState("R9");
  endtask

  task automatic testBulkEmpty();
    int cyc; logic e;
    issue(1'b0, 5'b00000, 32'h9999_9999, cyc, e);
    modelBulk(5'b00000, 32'h9999_9999);
    check("R2", "empty walk length", 128'(cyc), 5);
    checkState("R2");
  endtask

  initial begin
    #2000000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testBulkSparse();
    testBulkWrap();
    testRefine();
    testRefineBad();
    testIdleHold();
    testBusyIgnore();
    testRefine();
    testBulkEmpty();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule